// File: doc/BRIEF.md
# Power-Management Event and Timer Register Window

This block holds the power-management event status, event enable and control registers, along with a free-running power-management timer. All of them are reached through a relocatable 64-byte window on a 16-bit I/O address bus. The window base comes from a configuration value, and its low six address bits are dropped. A configuration enable bit switches the window on and off. Three event inputs raise status flags: power button, real-time-clock alarm and global lock. The timer raises its own flag whenever its most significant bit changes.

The block drives a registered, level-sensitive system control interrupt (SCI). SCI is high while any of four enabled status flags is set: timer, global lock, power button or RTC alarm. Software clears a flag by writing a one to it. Reads return data one cycle after the request, qualified by a valid strobe. Accesses that miss the window return nothing and change nothing.

Top module: `pm1_evt_tmr`

## Requirements
- R1: After reset, the status, enable and control registers and the timer read 0, `sci` is low and `io_rvalid` is low.
- R2: An access hits only while `cfg_win_en` is 1 and `io_addr & 0xFFC0` equals `cfg_pm_base & 0xFFC0`. A missed read gives no `io_rvalid`, and a missed write changes no register.
- R3: Only `io_addr[3:0]` selects a register. With `io_dw`=0, offset 0x0 is status, 0x2 is enable and 0x4 is control, all 16 bits wide. A hit read returns its data on `io_rdata` with `io_rvalid` high one cycle later. For example, offset 0x12 aliases offset 0x2.
- R4: A 16-bit read of any other offset returns 0, and a 16-bit write to any other offset has no effect.
- R5: A 32-bit read (`io_dw`=1) at offset 0x8 returns the timer value, zero-extended. All other 32-bit reads return 0, and 32-bit writes have no effect.
- R6: Status flags sit at bit 0 (timer), bit 5 (global lock), bit 8 (power button) and bit 10 (RTC). Writing 1 to a flag clears it, and writing 0 leaves it alone. All other status bits read 0.
- R7: A rising edge on `evt_pwrbtn`, `evt_rtc` or `evt_glock` sets its flag. A level that stays high does not set the flag again after it is cleared.
- R8: If a set and a clear hit the same flag in the same cycle, the flag ends up set.
- R9: The timer is a TMR_W-bit counter (24 bits by default). It advances by one in each cycle where `tmr_tick` is high, and wraps to 0.
- R10: The timer flag is set each time the timer's top bit changes value, which happens every 2^(TMR_W-1) ticks.
- R11: `sci` goes high one cycle after (status AND enable) has any of bits 0, 5, 8 or 10 set, and is low otherwise. Enable bits outside these four never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pm_base | input | 16 | Window base; bits 5:0 are ignored |
| cfg_win_en | input | 1 | Window enable |
| io_addr | input | 16 | I/O address |
| io_rd | input | 1 | Read request, one cycle |
| io_wr | input | 1 | Write request, one cycle |
| io_dw | input | 1 | Access size: 0 for 16-bit, 1 for 32-bit |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 32 | Registered read data |
| io_rvalid | output | 1 | Read data valid |
| evt_pwrbtn | input | 1 | Power button event |
| evt_rtc | input | 1 | RTC alarm event |
| evt_glock | input | 1 | Global lock event |
| tmr_tick | input | 1 | Timer advance enable |
| sci | output | 1 | System control interrupt, active high |

## Verification
The interrupt logic is tested with several enable patterns. An enable word containing none of the four interrupt bits, tried with every flag set, separates a design that masks correctly from one that ORs all enable bits. Enabling only global lock separates that source from the others. The window is probed in three ways: with the enable bit off, with a base that does not match, and with an aliased offset. Together these tell address gating apart from offset decode. The timer flag is checked one tick before and one tick after each change of the top bit, in both directions, which shows whether the design detects a change rather than a carry-out.

// File: rtl/pm1_pkg.sv
package pm1_pkg;
  localparam int unsigned FLG_TMR    = 0;
  localparam int unsigned FLG_GLOCK  = 5;
  localparam int unsigned FLG_PWRBTN = 8;
  localparam int unsigned FLG_RTC    = 10;

  localparam logic [15:0] FLG_MASK = (16'h1 << FLG_TMR) | (16'h1 << FLG_GLOCK) |
                                     (16'h1 << FLG_PWRBTN) | (16'h1 << FLG_RTC);

  typedef enum logic [3:0] {
    OFS_STS = 4'h0,
    OFS_EN  = 4'h2,
    OFS_CTL = 4'h4,
    OFS_TMR = 4'h8
  } pm_ofs_e;
endpackage

// File: rtl/pm1_win_dec.sv
module pm1_win_dec #(
  parameter int ADDR_W = 16,
  parameter int WIN_LSB = 6,
  parameter int OFS_W = 4
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [ADDR_W-1:0] base,
  input  logic              win_en,
  output logic              hit,
  output logic [OFS_W-1:0]  ofs
);
  localparam logic [ADDR_W-1:0] BASE_MASK = ~((ADDR_W'(1) << WIN_LSB) - ADDR_W'(1));

  assign hit = win_en && ((io_addr & BASE_MASK) == (base & BASE_MASK));
  assign ofs = io_addr[OFS_W-1:0];
endmodule

// File: rtl/pm1_tmr.sv
module pm1_tmr #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  output logic [W-1:0] count,
  output logic         top_flip
);
  assign top_flip = tick && (&count[W-2:0]);

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else if (tick) count <= count + W'(1);
  end

  a_r9_tick_adv: assert property (@(posedge clk) disable iff (rst)
    tick |=> count == $past(count) + W'(1));
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count));
endmodule

// File: rtl/pm1_evt_regs.sv
module pm1_evt_regs
  import pm1_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_sts,
  input  logic        wr_en,
  input  logic        wr_ctl,
  input  logic [15:0] wdata,
  input  logic        evt_pwrbtn,
  input  logic        evt_rtc,
  input  logic        evt_glock,
  input  logic        tmr_flip,
  output logic [15:0] sts_q,
  output logic [15:0] en_q,
  output logic [15:0] ctl_q,
  output logic        sci_q
);
  logic        pb_q, rtc_q, gl_q;
  logic [15:0] set_v, clr_v;

  always_comb begin
    set_v = '0;
    set_v[FLG_TMR]    = tmr_flip;
    set_v[FLG_GLOCK]  = evt_glock && !gl_q;
    set_v[FLG_PWRBTN] = evt_pwrbtn && !pb_q;
    set_v[FLG_RTC]    = evt_rtc && !rtc_q;
    clr_v = wr_sts ? wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pb_q  <= 1'b0;
      rtc_q <= 1'b0;
      gl_q  <= 1'b0;
      sts_q <= '0;
      en_q  <= '0;
      ctl_q <= '0;
      sci_q <= 1'b0;
    end else begin
      pb_q  <= evt_pwrbtn;
      rtc_q <= evt_rtc;
      gl_q  <= evt_glock;
      sts_q <= ((sts_q & ~clr_v) | set_v) & FLG_MASK;
      if (wr_en)  en_q  <= wdata;
      if (wr_ctl) ctl_q <= wdata;
      sci_q <= |(sts_q & en_q & FLG_MASK);
    end
  end

  a_r7_pb_edge: assert property (@(posedge clk) disable iff (rst)
    (evt_pwrbtn && !pb_q) |=> sts_q[FLG_PWRBTN]);
  a_r6_w1c: assert property (@(posedge clk) disable iff (rst)
    (wr_sts && wdata[FLG_GLOCK] && !(evt_glock && !gl_q)) |=> !sts_q[FLG_GLOCK]);
  a_r6_unimpl_zero: assert property (@(posedge clk) disable iff (rst)
    (sts_q & ~FLG_MASK) == 16'h0);
  a_r11_no_enable: assert property (@(posedge clk) disable iff (rst)
    ((en_q & FLG_MASK) == 16'h0) |=> !sci_q);
endmodule

// File: rtl/pm1_evt_tmr.sv
module pm1_evt_tmr
  import pm1_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WIN_LSB = 6,
  parameter int TMR_W = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfg_pm_base,
  input  logic              cfg_win_en,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic              io_dw,
  input  logic [15:0]       io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic              io_rvalid,
  input  logic              evt_pwrbtn,
  input  logic              evt_rtc,
  input  logic              evt_glock,
  input  logic              tmr_tick,
  output logic              sci
);
  localparam int OFS_W = 4;

  logic             hit;
  logic [OFS_W-1:0] ofs;
  logic [TMR_W-1:0] tmr_cnt;
  logic             tmr_flip;
  logic [15:0]      sts, en, ctl;
  logic             wr16;
  logic [DATA_W-1:0] rd_mux;

  pm1_win_dec #(.ADDR_W(ADDR_W), .WIN_LSB(WIN_LSB), .OFS_W(OFS_W)) u_dec (
    .io_addr(io_addr), .base(cfg_pm_base), .win_en(cfg_win_en),
    .hit(hit), .ofs(ofs)
  );

  pm1_tmr #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst(rst), .tick(tmr_tick), .count(tmr_cnt), .top_flip(tmr_flip)
  );

  assign wr16 = io_wr && hit && !io_dw;

  pm1_evt_regs u_regs (
    .clk(clk), .rst(rst),
    .wr_sts(wr16 && ofs == OFS_STS),
    .wr_en (wr16 && ofs == OFS_EN),
    .wr_ctl(wr16 && ofs == OFS_CTL),
    .wdata(io_wdata),
    .evt_pwrbtn(evt_pwrbtn), .evt_rtc(evt_rtc), .evt_glock(evt_glock),
    .tmr_flip(tmr_flip),
    .sts_q(sts), .en_q(en), .ctl_q(ctl), .sci_q(sci)
  );

  always_comb begin
    rd_mux = '0;
    if (io_dw) begin
      if (ofs == OFS_TMR) rd_mux = DATA_W'(tmr_cnt);
    end else begin
      case (ofs)
        OFS_STS: rd_mux = DATA_W'(sts);
        OFS_EN:  rd_mux = DATA_W'(en);
        OFS_CTL: rd_mux = DATA_W'(ctl);
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rvalid <= 1'b0;
      io_rdata  <= '0;
    end else begin
      io_rvalid <= io_rd && hit;
      io_rdata  <= (io_rd && hit) ? rd_mux : '0;
    end
  end

  a_r2_miss_silent: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !hit) |=> !io_rvalid);
  a_r2_miss_no_write: assert property (@(posedge clk) disable iff (rst)
    (io_wr && !hit) |=> $stable(en) && $stable(ctl));
  a_r5_dw_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_dw) |=> $stable(en) && $stable(ctl));
endmodule

// File: tb/pm1_evt_tmr_tb.sv
`timescale 1ns/1ps
module pm1_evt_tmr_tb;
  localparam int TW = 8;
  localparam logic [15:0] B = 16'hB000;

  logic clk = 0, rst = 1;
  logic [15:0] cfg_pm_base = 16'hB02A;
  logic cfg_win_en = 1;
  logic [15:0] io_addr = 0, io_wdata = 0;
  logic io_rd = 0, io_wr = 0, io_dw = 0;
  logic [31:0] io_rdata;
  logic io_rvalid, sci;
  logic evt_pwrbtn = 0, evt_rtc = 0, evt_glock = 0, tmr_tick = 0;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  pm1_evt_tmr #(.TMR_W(TW)) u_dut (
    .clk(clk), .rst(rst), .cfg_pm_base(cfg_pm_base), .cfg_win_en(cfg_win_en),
    .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .io_dw(io_dw),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
    .evt_pwrbtn(evt_pwrbtn), .evt_rtc(evt_rtc), .evt_glock(evt_glock),
    .tmr_tick(tmr_tick), .sci(sci)
  );

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (!rst && io_rvalid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R2 unexpected read data act=%h exp=none", io_rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (io_rdata !== e) begin
          n_fail++;
          $display("FAIL %s act=%h exp=%h", t, io_rdata, e);
        end
      end
    end
  end

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] e);
    n_chk++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", t, act, e);
    end
  endtask

  task automatic rd(input logic [15:0] a, input logic dw, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk); io_addr = a; io_dw = dw; io_rd = 1;
    @(negedge clk); io_rd = 0;
  endtask

  task automatic rd_none(input logic [15:0] a, input string t);
    @(negedge clk); io_addr = a; io_dw = 0; io_rd = 1;
    @(negedge clk); io_rd = 0;
    chk(t, {31'h0, io_rvalid}, 32'h0);
  endtask

  task automatic wr(input logic [15:0] a, input logic dw, input logic [15:0] d);
    @(negedge clk); io_addr = a; io_dw = dw; io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tmr_tick = 1;
      @(negedge clk); tmr_tick = 0;
    end
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 sci", {31'h0, sci}, 0);
    chk("R1 rvalid", {31'h0, io_rvalid}, 0);
    rd(B + 16'h0, 0, 0, "R1 status");
    rd(B + 16'h2, 0, 0, "R1 enable");
    rd(B + 16'h4, 0, 0, "R1 control");
    rd(B + 16'h8, 1, 0, "R1 timer");
    // R3 decode and alias
    wr(B + 16'h2, 0, 16'hFADE);
    wr(B + 16'h4, 0, 16'h1234);
    rd(B + 16'h2, 0, 32'hFADE, "R3 enable");
    rd(B + 16'h4, 0, 32'h1234, "R3 control");
    rd(B + 16'h12, 0, 32'hFADE, "R3 alias 0x12");
    // R4 undecoded 16-bit
    wr(B + 16'h6, 0, 16'hFFFF);
    rd(B + 16'h6, 0, 0, "R4 undecoded read");
    rd(B + 16'h4, 0, 32'h1234, "R4 write ignored");
    // R5 32-bit
    wr(B + 16'h2, 1, 16'h0000);
    rd(B + 16'h2, 0, 32'hFADE, "R5 dw write ignored");
    rd(B + 16'h0, 1, 0, "R5 dw read other");
    // R2 window gating
    cfg_win_en = 0;
    rd_none(B + 16'h2, "R2 disabled read");
    wr(B + 16'h2, 0, 16'h0000);
    cfg_win_en = 1;
    rd_none(B + 16'h42, "R2 other base read");
    wr(B + 16'h44, 0, 16'h0000);
    rd(B + 16'h2, 0, 32'hFADE, "R2 disabled write ignored");
    rd(B + 16'h4, 0, 32'h1234, "R2 miss write ignored");
    // R11 with enable having none of the four bits, all flags set
    @(negedge clk); evt_pwrbtn = 1; evt_rtc = 1; evt_glock = 1;
    settle(); settle();
    chk("R11 masked enable", {31'h0, sci}, 0);
    rd(B + 16'h0, 0, 32'h0520, "R7 three edges");
    // R7 held level after clear
    wr(B + 16'h0, 0, 16'hFFFF);
    rd(B + 16'h0, 0, 0, "R7 held level no reset");
    @(negedge clk); evt_pwrbtn = 0; evt_rtc = 0; evt_glock = 0;
    // R6 selective clear
    @(negedge clk); evt_rtc = 1; evt_glock = 1;
    @(negedge clk); evt_rtc = 0; evt_glock = 0;
    rd(B + 16'h0, 0, 32'h0420, "R6 set rtc+glock");
    wr(B + 16'h0, 0, 16'h0400);
    rd(B + 16'h0, 0, 32'h0020, "R6 w1c rtc only");
    // R11 enable glock only
    wr(B + 16'h2, 0, 16'h0020);
    settle();
    chk("R11 glock enabled", {31'h0, sci}, 1);
    wr(B + 16'h0, 0, 16'h0020);
    settle();
    chk("R11 cleared", {31'h0, sci}, 0);
    // R8 set wins
    @(negedge clk); io_addr = B; io_dw = 0; io_wdata = 16'h0100; io_wr = 1; evt_pwrbtn = 1;
    @(negedge clk); io_wr = 0; evt_pwrbtn = 0;
    rd(B + 16'h0, 0, 32'h0100, "R8 set wins");
    wr(B + 16'h0, 0, 16'hFFFF);
    // R9 / R10 timer
    wr(B + 16'h2, 0, 16'h0001);
    ticks(127);
    rd(B + 16'h8, 1, 127, "R9 count");
    rd(B + 16'h0, 0, 0, "R10 before flip");
    ticks(1);
    rd(B + 16'h8, 1, 128, "R9 count 128");
    rd(B + 16'h0, 0, 1, "R10 flip up");
    chk("R11 timer sci", {31'h0, sci}, 1);
    wr(B + 16'h0, 0, 16'h0001);
    ticks(127);
    rd(B + 16'h0, 0, 0, "R10 before wrap");
    ticks(1);
    rd(B + 16'h8, 1, 0, "R9 wrap");
    rd(B + 16'h0, 0, 1, "R10 flip down");
    repeat (3) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule